// File: doc/BRIEF.md
# Ballast Control Sequencer

This block runs the operating program of a lamp ballast controller as a microcoded state machine. A fixed control unit holds a 5-bit program counter. That counter addresses a 32-word, 64-bit program store, which sits outside the block. Each word carries one of eight commands. The commands can drive a bank of control outputs to the other functional blocks, test status flags, start and wait on a built-in time-out counter, accumulate immediate values, and leave an interrupt handler. Because the program store is separate, the ballast's behaviour can change by swapping the program without touching the control logic.

The program counter is presented directly as the store address, and the store returns the addressed word in the same cycle. The block therefore completes one instruction per clock, except while a wait command holds it. Any interrupt request line takes the program to a fixed vector at the top address. It remembers where to resume and ignores further requests until the handler executes its return command.

Instruction word layout, most significant bit first: command [63:61], jump target [60:56], flag select [55:52], output pattern [51:20], immediate [19:0].

Top module: `ballast_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the store address is 0, the control outputs are all zero, and the accumulator is zero. The time-out counter is also cleared, so its expiry flag is set.
- R2: Command 0 (set outputs) copies bits [51:20] of the word to the control outputs and advances the address by one. No other command changes the control outputs.
- R3: Address advance is modulo 32, so address 31 is followed by 0. Command 1 (jump) loads bits [60:56] as the next address.
- R4: Command 2 branches to bits [60:56] when the flag chosen by bits [55:52] is 1, and otherwise advances. Command 3 branches when that flag is 0. No other flag bit affects the choice.
- R5: Command 4 loads the time-out counter with bits [19:0]. The counter then decreases by one per clock and stops at zero.
- R6: Command 5 (wait) holds the address while the counter is non-zero and the selected flag is 0. It advances on the first edge at which either the count is zero or the flag is 1. A wait placed directly after a load of N therefore leaves the address N+1 cycles after the load executes.
- R7: Command 6 adds bits [19:0] to a 20-bit accumulator, modulo 2^20, and advances. No other command changes the accumulator.
- R8: When any interrupt line is high and no interrupt is in service, the fetched word is not executed. Its address is saved and the next address is 31.
- R9: While an interrupt is in service, requests are ignored. Command 7 (return) resumes at the saved address and re-enables interrupts, so a request still held is taken on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 5 | Program store address (program counter) |
| rom_data | input | 64 | Instruction word at rom_addr |
| flags | input | 16 | Status flags from the ballast blocks |
| irq | input | 4 | Interrupt request lines |
| ctrl_out | output | 32 | Registered control outputs |
| acc_out | output | 20 | Accumulator value |

## Verification
The assertions assume that rom_data is the word for the current rom_addr, settled before each edge. They also assume that flags and irq change only between edges. The bench models the program store as a combinational array indexed by rom_addr and changes every input at the falling edge. It reprograms the store only while reset is high, or at words that are not being fetched. Interrupt handlers in the test programs always begin with a jump at address 31, so the vector never executes an unintended command.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SETO = 3'd0,
    OP_JMP  = 3'd1,
    OP_BRS  = 3'd2,
    OP_BRC  = 3'd3,
    OP_LDT  = 3'd4,
    OP_WAIT = 3'd5,
    OP_ADDI = 3'd6,
    OP_RETI = 3'd7
  } op_e;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 4,
  parameter int OUT_W  = 32,
  parameter int IMM_W  = 20,
  parameter int WORD_W = OP_W + ADDR_W + SEL_W + OUT_W + IMM_W
) (
  input  logic [WORD_W-1:0] word,
  output op_e               op,
  output logic [ADDR_W-1:0] target,
  output logic [SEL_W-1:0]  sel,
  output logic [OUT_W-1:0]  outs,
  output logic [IMM_W-1:0]  imm
);
  localparam int TGT_HI = WORD_W - OP_W - 1;
  localparam int SEL_HI = TGT_HI - ADDR_W;
  localparam int OUT_HI = SEL_HI - SEL_W;

  always_comb begin
    op     = op_e'(word[WORD_W-1 -: OP_W]);
    target = word[TGT_HI -: ADDR_W];
    sel    = word[SEL_HI -: SEL_W];
    outs   = word[OUT_HI -: OUT_W];
    imm    = word[IMM_W-1:0];
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (load)
      count_q <= load_val;
    else if (count_q != '0)
      count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0);
endmodule

// File: rtl/seq_irq.sv
module seq_irq #(
  parameter int ADDR_W = 5,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IRQ_N-1:0]  req,
  input  logic              ret_exec,
  input  logic [ADDR_W-1:0] resume_addr,
  output logic              take,
  output logic              in_service,
  output logic [ADDR_W-1:0] ret_addr
);
  logic any_req;

  assign any_req = |req;
  assign take    = any_req && !in_service;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_service <= 1'b0;
      ret_addr   <= '0;
    end else if (take) begin
      in_service <= 1'b1;
      ret_addr   <= resume_addr;
    end else if (ret_exec) begin
      in_service <= 1'b0;
    end
  end
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 4,
  parameter int OUT_W  = 32,
  parameter int IMM_W  = 20,
  parameter int IRQ_N  = 4,
  parameter int WORD_W = OP_W + ADDR_W + SEL_W + OUT_W + IMM_W,
  parameter int FLAG_N = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [WORD_W-1:0] rom_data,
  input  logic [FLAG_N-1:0] flags,
  input  logic [IRQ_N-1:0]  irq,
  output logic [OUT_W-1:0]  ctrl_out,
  output logic [IMM_W-1:0]  acc_out
);
  localparam logic [ADDR_W-1:0] IRQ_VECTOR = {ADDR_W{1'b1}};

  op_e               op;
  logic [ADDR_W-1:0] target;
  logic [SEL_W-1:0]  sel;
  logic [OUT_W-1:0]  outs;
  logic [IMM_W-1:0]  imm;

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [OUT_W-1:0]  ctrl_q;
  logic [IMM_W-1:0]  acc_q;
  logic              out_en, acc_en, tmr_load, reti_en;
  logic              tmr_done, irq_take, in_svc, flag_hit;
  logic [ADDR_W-1:0] ret_addr;

  seq_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OUT_W(OUT_W), .IMM_W(IMM_W), .WORD_W(WORD_W)
  ) u_dec (
    .word(rom_data), .op(op), .target(target), .sel(sel), .outs(outs), .imm(imm)
  );

  seq_timer #(.CNT_W(IMM_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(imm), .expired(tmr_done)
  );

  seq_irq #(.ADDR_W(ADDR_W), .IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst), .req(irq), .ret_exec(reti_en), .resume_addr(pc_q),
    .take(irq_take), .in_service(in_svc), .ret_addr(ret_addr)
  );

  assign flag_hit = flags[sel];

  always_comb begin
    pc_d     = pc_q + 1'b1;
    out_en   = 1'b0;
    acc_en   = 1'b0;
    tmr_load = 1'b0;
    reti_en  = 1'b0;
    if (irq_take) begin
      pc_d = IRQ_VECTOR;
    end else begin
      unique case (op)
        OP_SETO: out_en = 1'b1;
        OP_JMP:  pc_d = target;
        OP_BRS:  if (flag_hit) pc_d = target;
        OP_BRC:  if (!flag_hit) pc_d = target;
        OP_LDT:  tmr_load = 1'b1;
        OP_WAIT: if (!tmr_done && !flag_hit) pc_d = pc_q;
        OP_ADDI: acc_en = 1'b1;
        OP_RETI: begin
          reti_en = 1'b1;
          pc_d    = ret_addr;
        end
        default: pc_d = pc_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ctrl_q <= '0;
      acc_q  <= '0;
    end else begin
      pc_q <= pc_d;
      if (out_en) ctrl_q <= outs;
      if (acc_en) acc_q <= acc_q + imm;
    end
  end

  assign rom_addr = pc_q;
  assign ctrl_out = ctrl_q;
  assign acc_out  = acc_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker
  import seq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int SEL_W  = 4,
  parameter int OUT_W  = 32,
  parameter int IMM_W  = 20,
  parameter int IRQ_N  = 4,
  parameter int WORD_W = 64,
  parameter int FLAG_N = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rom_addr,
  input logic [WORD_W-1:0] rom_data,
  input logic [FLAG_N-1:0] flags,
  input logic [IRQ_N-1:0]  irq,
  input logic [OUT_W-1:0]  ctrl_out,
  input logic [IMM_W-1:0]  acc_out,
  input logic              in_svc,
  input logic              tmr_done
);
  localparam int TGT_HI = WORD_W - OP_W - 1;
  localparam int SEL_HI = TGT_HI - ADDR_W;

  logic [OP_W-1:0]   c_op;
  logic [ADDR_W-1:0] c_tgt;
  logic [SEL_W-1:0]  c_sel;
  logic              c_take;

  assign c_op   = rom_data[WORD_W-1 -: OP_W];
  assign c_tgt  = rom_data[TGT_HI -: ADDR_W];
  assign c_sel  = rom_data[SEL_HI -: SEL_W];
  assign c_take = (|irq) && !in_svc;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (rom_addr == '0 && ctrl_out == '0 && acc_out == '0 && tmr_done));

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(c_op == OP_SETO && !c_take) |=> $stable(ctrl_out));

  p_jump_target_r3: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_JMP && !c_take) |=> rom_addr == $past(c_tgt));

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (c_op == OP_WAIT && !c_take && !tmr_done && !flags[c_sel]) |=> $stable(rom_addr));

  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(c_op == OP_ADDI && !c_take) |=> $stable(acc_out));

  p_vector_r8: assert property (@(posedge clk) disable iff (rst)
    c_take |=> (rom_addr == {ADDR_W{1'b1}} && in_svc));

  p_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (in_svc && c_op != OP_RETI) |=> in_svc);
endmodule

bind ballast_seq seq_checker #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OUT_W(OUT_W), .IMM_W(IMM_W),
  .IRQ_N(IRQ_N), .WORD_W(WORD_W), .FLAG_N(FLAG_N)
) u_chk (
  .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
  .flags(flags), .irq(irq), .ctrl_out(ctrl_out), .acc_out(acc_out),
  .in_svc(in_svc), .tmr_done(tmr_done)
);

// File: tb/ballast_seq_bench.sv
module ballast_seq_bench;
  localparam logic [2:0] C_SET = 3'd0, C_JMP = 3'd1, C_BRS = 3'd2, C_BRC = 3'd3,
                         C_LDT = 3'd4, C_WAIT = 3'd5, C_ADD = 3'd6, C_RET = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rom_addr;
  logic [63:0] rom_data;
  logic [15:0] flags = '0;
  logic [3:0]  irq = '0;
  logic [31:0] ctrl_out;
  logic [19:0] acc_out;
  logic [63:0] rom [32];

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  assign rom_data = rom[rom_addr];

  always #2 clk = ~clk;

  ballast_seq u_ballast_seq (
    .clk(clk), .rst(rst), .rom_addr(rom_addr), .rom_data(rom_data),
    .flags(flags), .irq(irq), .ctrl_out(ctrl_out), .acc_out(acc_out)
  );

  function automatic logic [63:0] mk(input logic [2:0] op, input logic [4:0] t,
                                     input logic [3:0] s, input logic [31:0] o,
                                     input logic [19:0] i);
    return {op, t, s, o, i};
  endfunction

  function automatic logic [31:0] pat(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (32'h1 << k);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_rom();
    for (int k = 0; k < 32; k++) rom[k] = mk(C_JMP, 5'(k), 4'd0, 32'd0, 20'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    irq = '0;
    step(2);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] sum;
    logic [19:0] imms [8];
    int cnt;
    clear_rom();
    @(negedge clk);
    step(2);
    // R1 reset state while held
    chk("R1 addr in reset", 64'(rom_addr), 0);
    chk("R1 ctrl in reset", 64'(ctrl_out), 0);
    chk("R1 acc in reset", 64'(acc_out), 0);

    // R2 / R3: set-outputs sweep across every address, including wrap 31 -> 0
    for (int k = 0; k < 32; k++) rom[k] = mk(C_SET, 5'd0, 4'd0, pat(k), 20'd0);
    do_reset();
    chk("R1 addr after reset", 64'(rom_addr), 0);
    for (int k = 0; k < 32; k++) begin
      step(1);
      chk("R2 outputs", 64'(ctrl_out), 64'(pat(k)));
      chk("R3 sequential addr", 64'(rom_addr), 64'((k + 1) % 32));
    end

    // R3 jump chain
    clear_rom();
    rom[0] = mk(C_JMP, 5'd17, 4'd0, 32'hFFFF_FFFF, 20'hFFFFF);
    rom[17] = mk(C_JMP, 5'd5, 4'd0, 32'd0, 20'd0);
    rom[5] = mk(C_JMP, 5'd30, 4'd0, 32'd0, 20'd0);
    rom[30] = mk(C_JMP, 5'd0, 4'd0, 32'd0, 20'd0);
    do_reset();
    step(1); chk("R3 jump 17", 64'(rom_addr), 17);
    step(1); chk("R3 jump 5", 64'(rom_addr), 5);
    step(1); chk("R3 jump 30", 64'(rom_addr), 30);
    step(1); chk("R3 jump 0", 64'(rom_addr), 0);
    chk("R2 ctrl untouched by jump", 64'(ctrl_out), 0);

    // R4 branch sweep: every select, both polarities, others opposite
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 2; b++) begin
        for (int c = 0; c < 2; c++) begin
          clear_rom();
          rom[0] = mk(c == 0 ? C_BRS : C_BRC, 5'd20, 4'(s), 32'd0, 20'd0);
          flags = (b == 1) ? (16'h1 << s) : ~(16'h1 << s);
          do_reset();
          step(1);
          chk("R4 branch", 64'(rom_addr), ((b == 1) == (c == 0)) ? 20 : 1);
        end
      end
    end
    flags = '0;

    // R5 / R6: load then wait, time to release is N+1 cycles
    for (int n = 0; n < 8; n++) begin
      clear_rom();
      rom[0] = mk(C_LDT, 5'd0, 4'd0, 32'd0, 20'(n));
      rom[1] = mk(C_WAIT, 5'd0, 4'd0, 32'd0, 20'd0);
      do_reset();
      step(1);
      chk("R5 after load", 64'(rom_addr), 1);
      cnt = 0;
      while (rom_addr != 5'd2 && cnt < 50) begin
        step(1);
        cnt++;
      end
      chk("R5 wait length", 64'(cnt), 64'(n + 1));
    end

    // R6 wait released by selected flag only
    clear_rom();
    rom[0] = mk(C_LDT, 5'd0, 4'd0, 32'd0, 20'd1000);
    rom[1] = mk(C_WAIT, 5'd0, 4'd3, 32'd0, 20'd0);
    do_reset();
    step(1);
    flags = ~16'h0008;
    step(5);
    chk("R6 other flags ignored", 64'(rom_addr), 1);
    flags = 16'h0008;
    step(1);
    chk("R6 flag release", 64'(rom_addr), 2);
    flags = '0;

    // R7 accumulator with wrap
    imms = '{20'h00001, 20'h7FFFF, 20'hF0000, 20'h12345,
             20'hFFFFF, 20'h0FFFF, 20'h80000, 20'h00010};
    clear_rom();
    for (int k = 0; k < 8; k++) rom[k] = mk(C_ADD, 5'd0, 4'd0, 32'd0, imms[k]);
    do_reset();
    sum = '0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      sum = sum + imms[k];
      chk("R7 accumulate", 64'(acc_out), 64'(sum));
    end
    step(2);
    chk("R7 acc held", 64'(acc_out), 64'(sum));
    chk("R2 ctrl held by add", 64'(ctrl_out), 0);

    // R8 / R9 interrupt on each line
    for (int i = 0; i < 4; i++) begin
      clear_rom();
      rom[0] = mk(C_SET, 5'd0, 4'd0, 32'd1, 20'd0);
      rom[1] = mk(C_SET, 5'd0, 4'd0, 32'd2, 20'd0);
      rom[2] = mk(C_SET, 5'd0, 4'd0, 32'd3, 20'd0);
      rom[31] = mk(C_JMP, 5'd24, 4'd0, 32'd0, 20'd0);
      rom[24] = mk(C_SET, 5'd0, 4'd0, 32'hAA, 20'd0);
      rom[25] = mk(C_RET, 5'd0, 4'd0, 32'd0, 20'd0);
      do_reset();
      step(1);
      irq = 4'(1 << i);
      step(1);
      chk("R8 vector", 64'(rom_addr), 31);
      chk("R8 fetched word skipped", 64'(ctrl_out), 1);
      step(1); chk("R9 masked in handler", 64'(rom_addr), 24);
      step(1); chk("R9 handler runs", 64'(ctrl_out), 32'hAA);
      step(1); chk("R9 return addr", 64'(rom_addr), 1);
      step(1); chk("R9 re-taken after return", 64'(rom_addr), 31);
      irq = '0;
      step(3); chk("R9 second return", 64'(rom_addr), 1);
      step(1); chk("R9 resumed word", 64'(ctrl_out), 2);
      step(1); chk("R9 continue", 64'(ctrl_out), 3);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule